// File: doc/BRIEF.md
# System Configuration Register Bank

A bank of 32-bit configuration words for chip-level settings, reached over a plain memory-mapped port with separate read and write strobes, a byte address and a 32-bit data bus. The byte address is turned into a word index by discarding its two lowest bits. Most words are ordinary read/write storage. A few words model PLL state and memory-remap controls. They come out of reset with fixed contents, and some of them refuse every write.

One word describes the clock tree. Its reset contents are built at elaboration from two peripheral-bus divisor parameters, each squeezed into a short logarithmic code. A divisor that is not a power of two, or is above 32, stops elaboration. An access whose word index falls past the end of the bank reads as zero and stores nothing. It also raises a sticky error flag, which software-facing logic outside the block can clear with a dedicated input.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two, so the two low address bits have no effect. Read data appears on `rdata` on the clock edge after `rd_en` is sampled high, and holds its value in cycles without `rd_en`.
- R2: Every word not listed in R3 to R6 resets to zero. A write to such an in-range word is stored and is returned by later reads.
- R3: Word 20 (PLL configuration) resets to 0x021A2358 and accepts writes.
- R4: Word 21 (PLL status) always reads 0x00000003. Writes to it have no effect.
- R5: Words 8, 9 and 10 (on-chip RAM control, external memory control, non-volatile memory remap base) reset to zero and ignore writes.
- R6: Word 3 (clock configuration) resets to code(DIV0) placed at bit 5 OR code(DIV1) placed at bit 2, with all other bits zero. It accepts writes. code(d) is the count of trailing zeros of d when d < 8, and that count plus one when d >= 8, giving 1→0, 2→1, 4→2, 8→4, 16→5 and 32→6. With the default divisors of 2, the reset value is 0x00000024.
- R7: A read of an index of 64 or more returns zero. A write to such an index changes no word, including the word whose index equals its low six bits.
- R8: `err` resets low. It goes high on the edge after any read or write to an out-of-range index and stays high until `err_clr` is sampled high. A new out-of-range access in the same cycle as `err_clr` leaves it set.
- R9: A read and a write to the same word in one cycle return the word's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (12) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err_clr | input | 1 | Clears the sticky error flag |
| err | output | 1 | Sticky out-of-range access flag |

## Verification
On every cycle the assertions check the following: that a write to an unlocked in-range word lands in storage, that the PLL status and remap words read back their fixed values, that out-of-range reads return zero, that `rdata` holds without a read, and how the error flag sets, clears and stays set. Some behaviour only the bench scenarios can show. This covers the reset contents of the whole bank, including the divisor-derived clock word. It also covers writes that alias past the end of the bank and leave their low-index twin untouched, the read-before-write ordering within a cycle, and long random mixes of reads, writes and clears checked against a bench-side model.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned IDX_CLKCFG  = 3;
  localparam int unsigned IDX_RAMCTL  = 8;
  localparam int unsigned IDX_DDRCTL  = 9;
  localparam int unsigned IDX_REMAP   = 10;
  localparam int unsigned IDX_PLLCFG  = 20;
  localparam int unsigned IDX_PLLSTAT = 21;

  localparam logic [31:0] PLLCFG_RST  = 32'h021A_2358;
  localparam logic [31:0] PLLSTAT_RST = 32'h0000_0003;

  // Log-style code of a power-of-two divisor.
  function automatic logic [2:0] div_code(int unsigned d);
    int unsigned tz;
    tz = 0;
    for (int i = 5; i >= 0; i--) begin
      if (((d >> i) & 1) == 1) tz = i;
    end
    if (d >= 8) tz = tz + 1;
    return tz[2:0];
  endfunction

  function automatic bit div_legal(int unsigned d);
    return (d != 0) && (d <= 32) && ((d & (d - 1)) == 0);
  endfunction

  // Words whose stored value never follows a write.
  function automatic bit is_locked(int unsigned i);
    return (i == IDX_PLLSTAT) || (i == IDX_RAMCTL) ||
           (i == IDX_DDRCTL)  || (i == IDX_REMAP);
  endfunction

  function automatic logic [31:0] rst_value(int unsigned i, logic [31:0] clkcfg);
    if (i == IDX_PLLCFG)  return PLLCFG_RST;
    if (i == IDX_PLLSTAT) return PLLSTAT_RST;
    if (i == IDX_CLKCFG)  return clkcfg;
    return 32'h0;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned N_WORDS = 64,
  localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              oob
);

  localparam int unsigned HI_W = ADDR_W - 2 - IDX_W;

  logic unused_low;
  assign unused_low = ^addr[1:0];
  assign idx = addr[IDX_W+1:2];

  generate
    if (HI_W > 0) begin : g_hi
      assign in_range = ~|addr[ADDR_W-1:IDX_W+2];
    end else begin : g_nohi
      assign in_range = 1'b1;
    end
  endgenerate

  assign oob = (rd_en | wr_en) & ~in_range;

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int unsigned N_WORDS     = 64,
  parameter logic [31:0] CLKCFG_RST  = 32'h24,
  localparam int unsigned IDX_W      = $clog2(N_WORDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_go,
  input  logic [IDX_W-1:0]          idx,
  input  logic [31:0]               wdata,
  output logic [N_WORDS-1:0][31:0]  word_q
);

  generate
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      localparam logic [31:0] RV = sysctl_pkg::rst_value(g, CLKCFG_RST);
      if (sysctl_pkg::is_locked(g)) begin : g_locked
        assign word_q[g] = RV;
      end else begin : g_rw
        logic        we;
        logic [31:0] nxt;
        always_comb begin
          we  = wr_go && (idx == IDX_W'(g));
          nxt = we ? wdata : word_q[g];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) word_q[g] <= RV;
          else        word_q[g] <= nxt;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sysctl_readport.sv
module sysctl_readport #(
  parameter int unsigned N_WORDS = 64,
  localparam int unsigned IDX_W  = $clog2(N_WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     in_range,
  input  logic                     oob,
  input  logic                     err_clr,
  input  logic [IDX_W-1:0]         idx,
  input  logic [N_WORDS-1:0][31:0] word_q,
  output logic [31:0]              rdata,
  output logic                     err
);

  logic [31:0] rdata_nxt;
  logic        err_nxt;

  always_comb begin
    rdata_nxt = rdata;
    if (rd_en) rdata_nxt = in_range ? word_q[idx] : 32'h0;
    err_nxt = (err & ~err_clr) | oob;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= 32'h0;
      err   <= 1'b0;
    end else begin
      rdata <= rdata_nxt;
      err   <= err_nxt;
    end
  end

  // R8: flag rises after any out-of-range access
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    oob |=> err);
  // R8: clear without new fault drops the flag
  a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !oob) |=> !err);
  // R8: flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
  // R1: no read strobe, read data holds
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned N_WORDS = 64,
  parameter int unsigned DIV0    = 2,
  parameter int unsigned DIV1    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              err_clr,
  output logic              err
);

  import sysctl_pkg::*;

  localparam int unsigned IDX_W = $clog2(N_WORDS);
  localparam logic [31:0] CLKCFG_RST =
    (32'(div_code(DIV0)) << 5) | (32'(div_code(DIV1)) << 2);

  generate
    if (!div_legal(DIV0) || !div_legal(DIV1)) begin : g_bad_div
      $error("divisor parameters must be powers of two no larger than 32");
    end
    if ((1 << IDX_W) != N_WORDS || N_WORDS <= IDX_PLLSTAT) begin : g_bad_depth
      $error("N_WORDS must be a power of two covering every named word");
    end
  endgenerate

  logic [IDX_W-1:0]         idx;
  logic                     in_range;
  logic                     oob;
  logic                     wr_go;
  logic [N_WORDS-1:0][31:0] word_q;

  sysctl_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_decode (
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .idx(idx), .in_range(in_range), .oob(oob)
  );

  assign wr_go = wr_en & in_range;

  sysctl_store #(.N_WORDS(N_WORDS), .CLKCFG_RST(CLKCFG_RST)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .idx(idx),
    .wdata(wdata), .word_q(word_q)
  );

  sysctl_readport #(.N_WORDS(N_WORDS)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .in_range(in_range),
    .oob(oob), .err_clr(err_clr), .idx(idx), .word_q(word_q),
    .rdata(rdata), .err(err)
  );

  // R2: write to an unlocked word lands in storage
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_range && !is_locked(int'(idx))) |=> word_q[$past(idx)] == $past(wdata));
  // R4: PLL status reads its fixed value
  a_r4_pllstat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_range && idx == IDX_W'(IDX_PLLSTAT)) |=> rdata == PLLSTAT_RST);
  // R5: remap controls read zero
  a_r5_remap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_range && (idx == IDX_W'(IDX_RAMCTL) || idx == IDX_W'(IDX_DDRCTL) ||
     idx == IDX_W'(IDX_REMAP))) |=> rdata == 32'h0);
  // R7: out-of-range read returns zero
  a_r7_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |=> rdata == 32'h0);

endmodule

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NW     = 64;
  localparam int unsigned D0     = 2;
  localparam int unsigned D1     = 2;

  logic              clk;
  logic              rst_n;
  logic              rd_en, wr_en, err_clr;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              err;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;

  logic [31:0] model [NW];
  logic [31:0] exp_rd;
  logic        exp_err;

  sysctl_regbank #(.ADDR_W(ADDR_W), .N_WORDS(NW), .DIV0(D0), .DIV1(D1)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err_clr(err_clr), .err(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int unsigned code_of(int unsigned d);
    int unsigned n = 0;
    int unsigned v = d;
    while (v > 1 && (v % 2) == 0) begin v = v / 2; n++; end
    return (d >= 8) ? n + 1 : n;
  endfunction

  function automatic bit locked(int unsigned i);
    return i == 21 || i == 8 || i == 9 || i == 10;
  endfunction

  function automatic string tag_of(int unsigned i);
    if (i >= NW)                     return "R7";
    if (i == 21)                     return "R4";
    if (i == 8 || i == 9 || i == 10) return "R5";
    if (i == 3)                      return "R6";
    if (i == 20)                     return "R3";
    return "R2";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NW; i++) model[i] = 32'h0;
    model[20] = 32'h021A_2358;
    model[21] = 32'h3;
    model[3]  = (code_of(D0) << 5) | (code_of(D1) << 2);
    exp_rd  = 32'h0;
    exp_err = 1'b0;
  endtask

  // Called at a falling edge; drives, waits one cycle, checks at next falling edge.
  task automatic bus(bit rd, bit wr, logic [ADDR_W-1:0] a, logic [31:0] d, bit clr, string req);
    int unsigned i;
    bit oob;
    i = int'(a >> 2);
    oob = (rd || wr) && (i >= NW);
    rd_en = rd; wr_en = wr; addr = a; wdata = d; err_clr = clr;
    if (rd) exp_rd = (i < NW) ? model[i] : 32'h0;
    exp_err = (exp_err & ~clr) | oob;
    if (wr && i < NW && !locked(i)) model[i] = d;
    @(negedge clk);
    check(req.len() ? req : (rd ? tag_of(i) : "R1"), rdata, exp_rd);
    check("R8", {31'b0, err}, {31'b0, exp_err});
    rd_en = 0; wr_en = 0; err_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rd_en = 0; wr_en = 0; err_clr = 0; addr = '0; wdata = '0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R8", {31'b0, err}, 32'h0);
    check("R1", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset contents of every word (R2 R3 R4 R5 R6)
    for (int i = 0; i < NW; i++) bus(1, 0, ADDR_W'(i * 4), 0, 0, "");
    check("R6", model[3], 32'h24);

    // Locked words ignore writes (R4 R5)
    bus(0, 1, ADDR_W'(21 * 4), 32'hFFFF_FFFF, 0, "R1");
    bus(1, 0, ADDR_W'(21 * 4), 0, 0, "R4");
    bus(0, 1, ADDR_W'(9 * 4), 32'hA5A5_0001, 0, "R1");
    bus(1, 0, ADDR_W'(9 * 4), 0, 0, "R5");

    // Writable named words (R3 R6)
    bus(0, 1, ADDR_W'(20 * 4), 32'h1234_5678, 0, "R1");
    bus(1, 0, ADDR_W'(20 * 4), 0, 0, "R3");
    bus(0, 1, ADDR_W'(3 * 4), 32'h0000_00FC, 0, "R1");
    bus(1, 0, ADDR_W'(3 * 4), 0, 0, "R6");

    // Low address bits ignored (R1)
    bus(0, 1, ADDR_W'(5 * 4 + 3), 32'hCAFE_0005, 0, "R1");
    bus(1, 0, ADDR_W'(5 * 4 + 1), 0, 0, "R1");

    // Aliasing write past the end leaves word 5 (R7), error set then held (R8)
    bus(0, 1, ADDR_W'((NW + 5) * 4), 32'hDEAD_BEEF, 0, "R7");
    bus(1, 0, ADDR_W'(5 * 4), 0, 0, "R7");
    bus(1, 0, ADDR_W'(200 * 4), 0, 0, "R7");
    bus(0, 0, 0, 0, 1, "R8");
    // Clear and new fault together: set wins (R8)
    bus(1, 0, ADDR_W'(900 * 4), 0, 1, "R8");
    bus(0, 0, 0, 0, 1, "R8");

    // Read and write same word in one cycle (R9)
    bus(1, 1, ADDR_W'(7 * 4), 32'h7777_0007, 0, "R9");
    bus(1, 0, ADDR_W'(7 * 4), 0, 0, "R9");

    // Random mix
    void'($urandom(32'd20240613));
    for (int k = 0; k < 4000; k++) begin
      int unsigned r;
      int unsigned wi;
      r  = $urandom;
      wi = (r[3:0] == 0) ? $urandom_range(NW, 1023) : $urandom_range(0, NW - 1);
      bus(r[4], r[5], ADDR_W'(wi * 4 + r[7:6]), $urandom, (r[11:8] == 0), "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule